// File: doc/BRIEF.md
# Address Computation Unit

This unit is a 16-bit address generator for a small processor datapath. Two adders work in the same cycle. The first adds a base register to an offset and forms the memory address. The second adds a base register to its own offset and forms a write-back value. The write-back value can be loaded into any of four pointer registers. The address sum itself can be loaded into the program counter.

The base for each adder is chosen by a 3-bit code. It selects the program counter, a saved-address register, the stack pointer, or one of two general pointers. The offset is the sum of every offset term that is enabled: small constants, the 8-bit low byte T sign-extended, and the 16-bit value {U, T}. A separate increment line adds one more, which reaches the second byte of a two-byte operand.

This one datapath performs the usual sequences. A push places S on the bus and writes S+1 back. A pop places S-1 on the bus and writes S-1 back. A relative branch adds the sign-extended T to the program counter. A call saves PC+1 into pointer Q, and a return jumps to Q.

Top module: `agu_core`

## Requirements
- R1: While rst_n is low, pc_q, v_q, s_q, p_q and q_q all become 0x0000.
- R2: A base code picks the base as follows: 1 selects the program counter, 2 the saved-address register V, 3 the stack pointer S, 4 pointer P and 5 pointer Q. Codes 0, 6 and 7 give a base of zero. The same encoding applies to ab_sel and wb_sel.
- R3: On the address path, the ab_ofs bits are weighted as follows: bit0 is +1, bit1 is +2, bit2 is -1 and bit3 is -4. All enabled terms are summed, and no enabled term gives an offset of zero. For example, bit3 and bit1 together give -2.
- R4: Bit 4 of either offset vector adds t_val sign-extended from bit 7. For example, T=0x80 adds -128 and T=0x7F adds +127.
- R5: Bit 5 of either offset vector adds the 16-bit value with u_val as the high byte and t_val as the low byte.
- R6: ab_inc adds 1 to the address sum and wb_inc adds 1 to the write-back sum, on top of the enabled offset terms.
- R7: Both sums wrap modulo 2^16.
- R8: On the write-back path, the wb_ofs bits 0 to 3 are weighted +1, +2, -1 and -2. At a rising clock edge, each of v_save, s_save, p_save and q_save loads the write-back sum into its own register and leaves the others unchanged.
- R9: When pc_save is high at a rising edge, pc_q takes the address sum. Otherwise pc_q holds its value.
- R10: When ab_drive is high, mem_addr equals the address sum and mem_addr_vld is 1. When ab_drive is low, both are 0.
- R11: A push puts S on mem_addr and leaves S+1 in s_q. A pop puts S-1 on mem_addr and leaves S-1 in s_q. A call leaves PC+1 in q_q, and a return taken through Q loads q_q into pc_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ab_sel | input | 3 | Base code for the address adder |
| ab_ofs | input | 6 | Offset term enables for the address adder |
| ab_inc | input | 1 | Adds one to the address sum |
| wb_sel | input | 3 | Base code for the write-back adder |
| wb_ofs | input | 6 | Offset term enables for the write-back adder |
| wb_inc | input | 1 | Adds one to the write-back sum |
| t_val | input | 8 | Low offset byte T |
| u_val | input | 8 | High offset byte U |
| pc_save | input | 1 | Loads the address sum into the program counter |
| v_save | input | 1 | Loads the write-back sum into V |
| s_save | input | 1 | Loads the write-back sum into S |
| p_save | input | 1 | Loads the write-back sum into P |
| q_save | input | 1 | Loads the write-back sum into Q |
| ab_drive | input | 1 | Drives the address sum onto the bus |
| mem_addr | output | 16 | Memory address |
| mem_addr_vld | output | 1 | Memory address is being driven |
| pc_q | output | 16 | Program counter |
| v_q | output | 16 | Saved-address register |
| s_q | output | 16 | Stack pointer |
| p_q | output | 16 | Pointer P |
| q_q | output | 16 | Pointer Q |

## Verification
The bench targets the constant weights that differ between the two paths: -4 on the address side and -2 on the write-back side. It also checks the -4 plus +2 combination. A design that swapped these weights, or that used OR instead of addition for the terms, would give wrong addresses. T=0x80 and T=0x7F test the sign extension; a design that zero-extended T would branch forward when it should branch backward. Wrap-around at 0xFFFF and 0x0000 is checked, and so is each save enable acting alone. A missing enable, or a register left writable, would show up as a changed pointer on the ports. The push, pop, call and return sequences confirm that the bus sees the pre-update S while s_q receives the post-update value.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    BASE_ZERO  = 3'd0,
    BASE_PC    = 3'd1,
    BASE_SAVED = 3'd2,
    BASE_STACK = 3'd3,
    BASE_PTR_P = 3'd4,
    BASE_PTR_Q = 3'd5
  } base_sel_e;

  localparam int OFS_N    = 6;
  localparam int OFS_REL  = 4;
  localparam int OFS_PAIR = 5;

  // constant weight of offset bits 0..2, identical on both paths
  function automatic int const_weight(int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return -1;
      default: return 0;
    endcase
  endfunction

  // add a signed integer to an unsigned word, wrapping at the word width
  function automatic logic [31:0] wrap_add(logic [31:0] acc, int term);
    return acc + 32'(term);
  endfunction
endpackage

// File: rtl/agu_base_sel.sv
module agu_base_sel #(
  parameter int AW = 16
) (
  input  logic [2:0]    sel,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] sv,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] pp,
  input  logic [AW-1:0] pq,
  output logic [AW-1:0] base
);
  import agu_pkg::*;

  always_comb begin
    case (base_sel_e'(sel))
      BASE_PC:    base = pc;
      BASE_SAVED: base = sv;
      BASE_STACK: base = sp;
      BASE_PTR_P: base = pp;
      BASE_PTR_Q: base = pq;
      default:    base = '0;
    endcase
  end
endmodule

// File: rtl/agu_ofs_gen.sv
module agu_ofs_gen #(
  parameter int AW      = 16,
  parameter int BW      = 8,
  parameter bit WB_PATH = 1'b0
) (
  input  logic [agu_pkg::OFS_N-1:0] en,
  input  logic                      inc,
  input  logic [BW-1:0]             t,
  input  logic [BW-1:0]             u,
  output logic [AW-1:0]             ofs
);
  import agu_pkg::*;

  localparam int PAIR_W = 2 * BW;

  int k3;
  generate
    if (WB_PATH) begin : g_wb_k3
      assign k3 = -2;
    end else begin : g_ab_k3
      assign k3 = -4;
    end
  endgenerate

  logic [AW-1:0] rel_ext;
  logic [AW-1:0] pair_ext;
  assign rel_ext  = {{(AW-BW){t[BW-1]}}, t};
  assign pair_ext = AW'({u, t});

  logic [31:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < 3; i++) begin
      if (en[i]) acc = wrap_add(acc, const_weight(i));
    end
    if (en[3])        acc = wrap_add(acc, k3);
    if (en[OFS_REL])  acc = acc + 32'(rel_ext);
    if (en[OFS_PAIR]) acc = acc + 32'(pair_ext);
    if (inc)          acc = acc + 32'd1;
  end

  assign ofs = acc[AW-1:0];

  logic unused_pair;
  assign unused_pair = (PAIR_W > AW);
endmodule

// File: rtl/agu_core.sv
module agu_core #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ab_sel,
  input  logic [5:0]    ab_ofs,
  input  logic          ab_inc,
  input  logic [2:0]    wb_sel,
  input  logic [5:0]    wb_ofs,
  input  logic          wb_inc,
  input  logic [BW-1:0] t_val,
  input  logic [BW-1:0] u_val,
  input  logic          pc_save,
  input  logic          v_save,
  input  logic          s_save,
  input  logic          p_save,
  input  logic          q_save,
  input  logic          ab_drive,
  output logic [AW-1:0] mem_addr,
  output logic          mem_addr_vld,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] v_q,
  output logic [AW-1:0] s_q,
  output logic [AW-1:0] p_q,
  output logic [AW-1:0] q_q
);
  localparam int NPTR = 4;

  // internal events exposed for the checker
  logic [AW-1:0] ab_base, ab_offset, ab_sum;
  logic [AW-1:0] wb_base, wb_offset, wb_sum;

  logic [AW-1:0] pc_r;
  logic [AW-1:0] ptr_r [NPTR];
  logic [NPTR-1:0] ptr_save;
  assign ptr_save = {q_save, p_save, s_save, v_save};

  agu_base_sel #(.AW(AW)) u_ab_base (
    .sel(ab_sel), .pc(pc_r), .sv(ptr_r[0]), .sp(ptr_r[1]),
    .pp(ptr_r[2]), .pq(ptr_r[3]), .base(ab_base)
  );

  agu_base_sel #(.AW(AW)) u_wb_base (
    .sel(wb_sel), .pc(pc_r), .sv(ptr_r[0]), .sp(ptr_r[1]),
    .pp(ptr_r[2]), .pq(ptr_r[3]), .base(wb_base)
  );

  agu_ofs_gen #(.AW(AW), .BW(BW), .WB_PATH(1'b0)) u_ab_ofs (
    .en(ab_ofs), .inc(ab_inc), .t(t_val), .u(u_val), .ofs(ab_offset)
  );

  agu_ofs_gen #(.AW(AW), .BW(BW), .WB_PATH(1'b1)) u_wb_ofs (
    .en(wb_ofs), .inc(wb_inc), .t(t_val), .u(u_val), .ofs(wb_offset)
  );

  assign ab_sum = ab_base + ab_offset;
  assign wb_sum = wb_base + wb_offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_r <= '0;
    else if (pc_save) pc_r <= ab_sum;
  end

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ptr_r[g] <= '0;
        else if (ptr_save[g]) ptr_r[g] <= wb_sum;
      end
    end
  endgenerate

  assign mem_addr     = ab_drive ? ab_sum : '0;
  assign mem_addr_vld = ab_drive;
  assign pc_q = pc_r;
  assign v_q  = ptr_r[0];
  assign s_q  = ptr_r[1];
  assign p_q  = ptr_r[2];
  assign q_q  = ptr_r[3];
endmodule

// File: rtl/agu_core_chk.sv
module agu_core_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    ab_sel,
  input logic [5:0]    ab_ofs,
  input logic          ab_inc,
  input logic          pc_save,
  input logic          s_save,
  input logic          q_save,
  input logic          ab_drive,
  input logic [AW-1:0] mem_addr,
  input logic          mem_addr_vld,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] s_q,
  input logic [AW-1:0] q_q,
  input logic [AW-1:0] ab_sum,
  input logic [AW-1:0] wb_sum
);
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_save |=> $stable(pc_q)); // R9
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_save |=> pc_q == $past(ab_sum)); // R9
  AST_S_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    s_save |=> s_q == $past(wb_sum)); // R8
  AST_Q_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    q_save |=> q_q == $past(wb_sum)); // R8
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_drive |-> (mem_addr == '0) && !mem_addr_vld); // R10
  AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_drive && ab_sel == 3'd3 && ab_ofs == '0 && !ab_inc) |-> mem_addr == s_q); // R11
endmodule

bind agu_core agu_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ab_sel(ab_sel), .ab_ofs(ab_ofs), .ab_inc(ab_inc),
  .pc_save(pc_save), .s_save(s_save), .q_save(q_save), .ab_drive(ab_drive),
  .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld), .pc_q(pc_q), .s_q(s_q),
  .q_q(q_q), .ab_sum(ab_sum), .wb_sum(wb_sum)
);

// File: tb/agu_core_bench.sv
module agu_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] ab_sel = '0, wb_sel = '0;
  logic [5:0] ab_ofs = '0, wb_ofs = '0;
  logic ab_inc = 0, wb_inc = 0, ab_drive = 0;
  logic [7:0] t_val = '0, u_val = '0;
  logic pc_save = 0, v_save = 0, s_save = 0, p_save = 0, q_save = 0;
  logic [15:0] mem_addr, pc_q, v_q, s_q, p_q, q_q;
  logic mem_addr_vld;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] e_pc = 0, e_v = 0, e_s = 0, e_p = 0, e_q = 0;

  always #4 clk = ~clk;

  agu_core u_agu_core (
    .clk(clk), .rst_n(rst_n), .ab_sel(ab_sel), .ab_ofs(ab_ofs), .ab_inc(ab_inc),
    .wb_sel(wb_sel), .wb_ofs(wb_ofs), .wb_inc(wb_inc), .t_val(t_val), .u_val(u_val),
    .pc_save(pc_save), .v_save(v_save), .s_save(s_save), .p_save(p_save),
    .q_save(q_save), .ab_drive(ab_drive), .mem_addr(mem_addr),
    .mem_addr_vld(mem_addr_vld), .pc_q(pc_q), .v_q(v_q), .s_q(s_q), .p_q(p_q), .q_q(q_q)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] bref(logic [2:0] sel);
    if (sel == 1) return e_pc;
    if (sel == 2) return e_v;
    if (sel == 3) return e_s;
    if (sel == 4) return e_p;
    if (sel == 5) return e_q;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] oref(bit wb, logic [5:0] en, bit inc, logic [7:0] t, logic [7:0] u);
    int s = 0;
    if (en[0]) s += 1;
    if (en[1]) s += 2;
    if (en[2]) s -= 1;
    if (en[3]) s += wb ? -2 : -4;
    if (en[4]) s += (int'(t) > 127) ? int'(t) - 256 : int'(t);
    if (en[5]) s += int'(u) * 256 + int'(t);
    if (inc)   s += 1;
    return 16'(s);
  endfunction

  function automatic logic [15:0] wrapadd(logic [15:0] a, logic [15:0] b);
    int s = int'(a) + int'(b);
    return 16'(s % 65536);
  endfunction

  // one cycle: apply, check bus, clock, check all registers
  task automatic step(string req, logic [2:0] as, logic [5:0] ao, bit ai,
                      logic [2:0] ws, logic [5:0] wo, bit wi, logic [7:0] t, logic [7:0] u,
                      logic [4:0] sv, bit drv);
    logic [15:0] a_exp, w_exp;
    @(negedge clk);
    ab_sel = as; ab_ofs = ao; ab_inc = ai; wb_sel = ws; wb_ofs = wo; wb_inc = wi;
    t_val = t; u_val = u; ab_drive = drv;
    {pc_save, v_save, s_save, p_save, q_save} = sv;
    a_exp = wrapadd(bref(as), oref(0, ao, ai, t, u));
    w_exp = wrapadd(bref(ws), oref(1, wo, wi, t, u));
    #1;
    chk({req, " bus"}, mem_addr, drv ? a_exp : 16'h0000);
    chk({req, " vld"}, {15'd0, mem_addr_vld}, {15'd0, drv});
    if (sv[4]) e_pc = a_exp;
    if (sv[3]) e_v = w_exp;
    if (sv[2]) e_s = w_exp;
    if (sv[1]) e_p = w_exp;
    if (sv[0]) e_q = w_exp;
    @(posedge clk); #1;
    {pc_save, v_save, s_save, p_save, q_save} = '0;
    chk({req, " pc"}, pc_q, e_pc);
    chk({req, " v"}, v_q, e_v);
    chk({req, " s"}, s_q, e_s);
    chk({req, " p"}, p_q, e_p);
    chk({req, " q"}, q_q, e_q);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 pc", pc_q, 0); chk("R1 v", v_q, 0); chk("R1 s", s_q, 0);
    chk("R1 p", p_q, 0); chk("R1 q", q_q, 0);
  endtask

  task automatic t_load();
    step("R5 R8 load v", 0, 0, 0, 0, 6'h20, 0, 8'hEF, 8'hBE, 5'b01000, 0);
    step("R8 load s", 0, 0, 0, 0, 6'h20, 0, 8'h00, 8'h01, 5'b00100, 0);
    step("R8 load p", 0, 0, 0, 0, 6'h20, 0, 8'h34, 8'h12, 5'b00010, 0);
    step("R8 load q", 0, 0, 0, 0, 6'h20, 0, 8'h00, 8'h40, 5'b00001, 0);
    step("R9 load pc", 0, 6'h20, 0, 0, 0, 0, 8'h00, 8'h02, 5'b10000, 1);
  endtask

  task automatic t_base();
    for (int k = 0; k < 8; k++) step("R2 base", 3'(k), 0, 0, 3'(7 - k), 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_consts();
    logic [5:0] pats [7] = '{6'h00, 6'h01, 6'h02, 6'h04, 6'h08, 6'h0A, 6'h0F};
    for (int k = 0; k < 7; k++) step("R3 const", 3'd4, pats[k], 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_rel();
    step("R4 rel neg", 3'd1, 6'h10, 0, 0, 0, 0, 8'h80, 8'h00, 0, 1);
    step("R4 rel pos", 3'd1, 6'h10, 0, 0, 0, 0, 8'h7F, 8'h00, 0, 1);
    step("R4 branch", 3'd1, 6'h10, 0, 0, 0, 0, 8'hF0, 8'h00, 5'b10000, 1);
  endtask

  task automatic t_inc();
    step("R6 second byte", 3'd4, 6'h20, 1, 3'd5, 6'h20, 1, 8'hFF, 8'h00, 5'b00010, 1);
    step("R6 wb inc", 0, 0, 1, 3'd2, 6'h00, 1, 0, 0, 5'b01000, 1);
  endtask

  task automatic t_wrap();
    step("R7 set s", 0, 0, 0, 0, 6'h20, 0, 8'hFF, 8'hFF, 5'b00100, 0);
    step("R7 wrap up", 3'd3, 6'h01, 0, 3'd3, 6'h01, 0, 0, 0, 5'b00100, 1);
    step("R7 wrap down", 3'd0, 6'h04, 0, 3'd0, 6'h0C, 0, 0, 0, 5'b00010, 1);
  endtask

  task automatic t_wb_consts();
    step("R8 wb m2", 3'd2, 0, 0, 3'd2, 6'h08, 0, 0, 0, 5'b01000, 1);
    step("R8 wb mix", 3'd5, 0, 0, 3'd5, 6'h07, 0, 0, 0, 5'b00001, 1);
    step("R8 wb rel", 0, 0, 0, 3'd4, 6'h10, 0, 8'h85, 0, 5'b00010, 1);
  endtask

  task automatic t_stack();
    step("R11 set s", 0, 0, 0, 0, 6'h20, 0, 8'h10, 8'h03, 5'b00100, 0);
    step("R11 push", 3'd3, 0, 0, 3'd3, 6'h01, 0, 0, 0, 5'b00100, 1);
    step("R11 push2", 3'd3, 0, 0, 3'd3, 6'h01, 0, 0, 0, 5'b00100, 1);
    step("R11 pop", 3'd3, 6'h04, 0, 3'd3, 6'h04, 0, 0, 0, 5'b00100, 1);
    step("R11 call", 3'd1, 0, 0, 3'd1, 6'h01, 0, 0, 0, 5'b00001, 1);
    step("R11 ret", 3'd5, 0, 0, 0, 0, 0, 0, 0, 5'b10000, 1);
  endtask

  task automatic t_gate();
    step("R10 no drive", 3'd3, 6'h01, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R10 drive", 3'd3, 6'h01, 1, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_load();
    t_base();
    t_consts();
    t_rel();
    t_inc();
    t_wrap();
    t_wb_consts();
    t_stack();
    t_gate();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule